// File: doc/BRIEF.md
# Carrier-Timed Manchester / Biphase Line Encoder

This block turns a serial stream of data bits into a modulation-switch control waveform, using either Manchester or biphase line coding. All of its timing is counted in cycles of the carrier clock that drives it. Each bit occupies either 64 or 32 carrier cycles, selected by an input. The block pulls one data bit at a time from an upstream frame source by raising a one-cycle request strobe at the end of every bit period.

The control output is high when the modulation switch is to be open (OFF) and low when it is to be closed (ON). The code, the rate and the data bit are all captured together on the request edge. As a result, the line code and the bit period can be changed between any two bits while the block runs, and changes in the middle of a bit do not disturb the bit being sent. The first half of a bit is the first period/2 cycles after the request edge that loaded it.

Top module: `carrier_line_encoder`

## Requirements
- R1: With `rate_sel`=0 a bit lasts 64 carrier cycles and with `rate_sel`=1 it lasts 32. `bit_req` is high for exactly one cycle, the last cycle of each bit.
- R2: `data_in`, `code_sel` and `rate_sel` are captured only on a rising clock edge where `bit_req` is high. Changing them at any other time has no effect on `mod_out` or on the timing of `bit_req`.
- R3: With `code_sel`=0 (Manchester), a 1 is sent as high (switch OFF) for the first half of the bit and low (switch ON) for the second half. A 0 is sent as low, then high.
- R4: In Manchester code, `mod_out` changes level at the middle of every bit, between cycle period/2-1 and cycle period/2 of the bit.
- R5: With `code_sel`=1 (biphase), `mod_out` changes level at the start of every bit, relative to the level it had in the last cycle of the previous bit.
- R6: In biphase code, a 1 keeps one level for the whole bit. A 0 changes level again at the middle of the bit.
- R7: While reset is held and until the first bit is loaded, `mod_out` is high and `bit_req` is high, so the first bit is requested immediately. A biphase first bit therefore starts low.
- R8: The code may change from one bit to the next. A biphase bit always starts at the inverse of the line level in the last cycle of the preceding bit, whichever code that bit used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous active-high reset |
| code_sel | input | 1 | Line code: 0 Manchester, 1 biphase |
| rate_sel | input | 1 | Bit period: 0 = 64 cycles, 1 = 32 cycles |
| data_in | input | 1 | Next data bit, captured when `bit_req` is high |
| mod_out | output | 1 | Modulation control: 1 switch OFF, 0 switch ON |
| bit_req | output | 1 | One-cycle strobe asking for the next bit |

## Verification
The bench builds the block with its default bit periods of 64 and 32 cycles. These are short enough to sweep every 4-bit data sequence under each of the four code and rate combinations, checking the line level in every carrier cycle. The sweep covers every pairing of adjacent bit values, so each start-of-bit and mid-bit edge case occurs under both codes. The inputs are scrambled partway through every bit to show they are ignored outside the request edge. A final run alternates the code from bit to bit, to exercise the way the biphase start level follows the preceding bit.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef enum logic {
        CODE_MANCHESTER = 1'b0,
        CODE_BIPHASE    = 1'b1
    } line_code_e;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } bit_rate_e;

    parameter int unsigned DEF_SLOW_CYCLES = 64;
    parameter int unsigned DEF_FAST_CYCLES = 32;

    // Symbol captured at each bit boundary
    typedef struct packed {
        logic       bit_val;
        line_code_e code;
        logic       start_lvl;
    } symbol_t;

    function automatic int unsigned period_of(bit_rate_e r, int unsigned slow_c,
                                              int unsigned fast_c);
        return (r == RATE_FAST) ? fast_c : slow_c;
    endfunction

    // Level driven in a given half of the bit
    function automatic logic level_of(symbol_t s, logic in_first_half);
        logic lvl;
        if (s.code == CODE_MANCHESTER)
            lvl = in_first_half ? s.bit_val : ~s.bit_val;
        else if (in_first_half || s.bit_val)
            lvl = s.start_lvl;
        else
            lvl = ~s.start_lvl;
        return lvl;
    endfunction

endpackage

// File: rtl/lc_bit_timer.sv
module lc_bit_timer
    import lc_pkg::*;
#(
    parameter int unsigned SLOW_CYCLES = DEF_SLOW_CYCLES,
    parameter int unsigned FAST_CYCLES = DEF_FAST_CYCLES
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_rate_e rate_in,
    output logic      boundary,
    output logic      first_half,
    output logic      active
);
    localparam int unsigned CW = $clog2(SLOW_CYCLES);

    logic [CW-1:0] remain;
    bit_rate_e     cur_rate;
    logic [CW-1:0] load_val;
    logic [CW-1:0] half_val;
    logic [CW-1:0] last_cur;

    assign load_val = CW'(period_of(rate_in, SLOW_CYCLES, FAST_CYCLES) - 1);
    assign half_val = CW'(period_of(cur_rate, SLOW_CYCLES, FAST_CYCLES) / 2);
    assign last_cur = CW'(period_of(cur_rate, SLOW_CYCLES, FAST_CYCLES) - 1);

    assign boundary   = (remain == '0);
    assign first_half = active && (remain >= half_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain   <= '0;
            cur_rate <= RATE_SLOW;
            active   <= 1'b0;
        end else if (boundary) begin
            remain   <= load_val;
            cur_rate <= rate_in;
            active   <= 1'b1;
        end else begin
            remain   <= remain - 1'b1;
        end
    end

    // R1
    remain_range_chk: assert property (@(posedge clk) disable iff (rst)
        remain <= last_cur);

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> !boundary);

endmodule

// File: rtl/lc_line_encoder.sv
module lc_line_encoder
    import lc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       boundary,
    input  logic       first_half,
    input  logic       active,
    input  logic       data_in,
    input  line_code_e code_in,
    output logic       mod_o
);
    symbol_t sym;

    always_comb begin
        if (!active) mod_o = 1'b1;
        else         mod_o = level_of(sym, first_half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym.bit_val   <= 1'b0;
            sym.code      <= CODE_MANCHESTER;
            sym.start_lvl <= 1'b1;
        end else if (boundary) begin
            sym.bit_val   <= data_in;
            sym.code      <= code_in;
            sym.start_lvl <= ~mod_o;
        end
    end

    // R4
    manch_mid_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(first_half) && active && sym.code == CODE_MANCHESTER)
        |-> (mod_o != $past(mod_o)));

    // R5
    biph_start_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (sym.code != CODE_BIPHASE || mod_o != $past(mod_o)));

    // R6
    biph_one_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(first_half) && active && sym.code == CODE_BIPHASE && sym.bit_val)
        |-> $stable(mod_o));

    // R6
    biph_zero_mid_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(first_half) && active && sym.code == CODE_BIPHASE && !sym.bit_val)
        |-> (mod_o != $past(mod_o)));

    // R7
    idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> mod_o);

endmodule

// File: rtl/carrier_line_encoder.sv
module carrier_line_encoder
    import lc_pkg::*;
#(
    parameter int unsigned SLOW_CYCLES = DEF_SLOW_CYCLES,
    parameter int unsigned FAST_CYCLES = DEF_FAST_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic code_sel,
    input  logic rate_sel,
    input  logic data_in,
    output logic mod_out,
    output logic bit_req
);
    logic boundary;
    logic first_half;
    logic active;

    lc_bit_timer #(
        .SLOW_CYCLES(SLOW_CYCLES),
        .FAST_CYCLES(FAST_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rate_in   (bit_rate_e'(rate_sel)),
        .boundary  (boundary),
        .first_half(first_half),
        .active    (active)
    );

    lc_line_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .first_half(first_half),
        .active    (active),
        .data_in   (data_in),
        .code_in   (line_code_e'(code_sel)),
        .mod_o     (mod_out)
    );

    assign bit_req = boundary;

endmodule

// File: tb/carrier_line_encoder_test.sv
module carrier_line_encoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic code_sel = 1'b0;
    logic rate_sel = 1'b0;
    logic data_in = 1'b0;
    logic mod_out;
    logic bit_req;

    int checks = 0;
    int errors = 0;
    logic prev_end = 1'b1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    carrier_line_encoder uut (
        .clk(clk), .rst(rst), .code_sel(code_sel), .rate_sel(rate_sel),
        .data_in(data_in), .mod_out(mod_out), .bit_req(bit_req)
    );

    task automatic check(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Called at a negedge with bit_req high; sends one bit and ends at the
    // negedge of its last cycle.
    task automatic send_bit(logic d, logic c, logic r, string base);
        int   p     = r ? 32 : 64;
        logic start = c ? ~prev_end : d;
        logic exp;
        data_in  = d;
        code_sel = c;
        rate_sel = r;
        for (int k = 0; k < p; k++) begin
            @(negedge clk);
            if (k == 5) begin
                data_in  = ~d;
                code_sel = ~c;
                rate_sel = ~r;
            end
            if (!c) exp = (k < p/2) ? d : ~d;
            else    exp = (k < p/2 || d) ? start : ~start;
            if (!c && k == p/2)
                check(mod_out, exp, {base, " R4 manchester mid"});
            else if (!c)
                check(mod_out, exp, {base, (k > 5) ? " R3 R2" : " R3"});
            else if (k == 0)
                check(mod_out, exp, {base, " R5 biphase start"});
            else
                check(mod_out, exp, {base, (k > 5) ? " R6 R2" : " R6"});
            check(bit_req, (k == p-1), {base, " R1 R2 strobe"});
        end
        prev_end = exp;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mod_out, 1'b1, "R7 reset level");
        check(bit_req, 1'b1, "R7 reset request");
        rst = 1'b0;
        check(mod_out, 1'b1, "R7 idle level");
        // First bit biphase: must start low
        send_bit(1'b1, 1'b1, 1'b1, "R7 first");
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 2; r++)
                for (int pat = 0; pat < 16; pat++)
                    for (int b = 0; b < 4; b++)
                        send_bit(pat[b], c[0], r[0], "sweep");
        for (int i = 0; i < 16; i++)
            send_bit(16'hB4D2 >> i, i[0], i[2], "R8 switch");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule